// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block sequences the operating mode of a low-power radio transceiver's digital core. Three pins control it. An active-low reset holds the core in Off. A level-held enable starts a receive or transmit sequence on its rising edge, and its low level forces Idle. An active-low attention pin is the only way out of the two low-power states.

Register-style inputs select the kind of sequence, request a low-power state, and switch two GPIO pins to status duty. The RF datapath reports the end of a sequence on `seq_done_i`. It reports the CRC result on `crc_ok_i`.

The block drives an encoded mode, a one-cycle start strobe to the datapath and a busy flag. When the alternate function is enabled, it also drives an out-of-idle indicator on GPIO1 and a latched CRC-valid indicator on GPIO2. The enable and attention inputs, and the release of reset, each pass through a two-stage synchronizer before the state machine uses them.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: While `rst_ni` is low, `mode_o` is Off (code 0) and `start_o` and `busy_o` are low; an assertion of reset in the middle of a sequence takes effect without waiting for a clock.
- R2: After `rst_ni` rises, `mode_o` stays Off for two clock edges and becomes Idle (code 1) on the third edge.
- R3: In Idle, a rising edge on `trx_en_i` enters RX (code 2) if `seq_tx_i` is 0, or TX (code 3) if `seq_tx_i` is 1. The mode changes on the third clock edge after the pin rises.
- R4: `start_o` is high for exactly the first cycle of RX or TX. `busy_o` is high for the whole time the mode is RX or TX.
- R5: A low level on `trx_en_i` during RX or TX aborts to Idle on the third edge after the pin falls, and `busy_o` drops.
- R6: `seq_done_i` high during RX or TX returns the mode to Idle on the next edge. No new sequence starts until `trx_en_i` has gone low and then high again.
- R7: `lp_req_i` high in Idle enters Doze (code 4) if `lp_sel_i` is 0, or Hibernate (code 5) if `lp_sel_i` is 1, on the next edge. The request is ignored in every other mode.
- R8: In Doze or Hibernate, `trx_en_i` is ignored. `attn_ni` low returns the mode to Idle on the third edge. An enable edge that happened while in low power does not start a sequence after wake-up.
- R9: With `gpio_alt_i` = 1, `gpio1_o` is high exactly while the mode is RX or TX. With `gpio_alt_i` = 0, `gpio1_o` follows `gpio_dflt_i[0]`.
- R10: A CRC flag captures `crc_ok_i` when a receive sequence ends through `seq_done_i` and is cleared on entry to RX or TX. `gpio2_o` shows the flag when `gpio_alt_i` = 1 and follows `gpio_dflt_i[1]` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trx_en_i | input | 1 | Asynchronous level-held sequence enable |
| attn_ni | input | 1 | Asynchronous active-low wake request |
| seq_tx_i | input | 1 | Sequence type: 0 receive, 1 transmit |
| lp_req_i | input | 1 | Request to leave Idle for a low-power state |
| lp_sel_i | input | 1 | Low-power target: 0 Doze, 1 Hibernate |
| gpio_alt_i | input | 1 | Routes status indicators onto the GPIO pins |
| seq_done_i | input | 1 | Datapath reports sequence completion |
| crc_ok_i | input | 1 | CRC result, valid with `seq_done_i` |
| gpio_dflt_i | input | 2 | Plain GPIO values used when the alternate function is off |
| mode_o | output | 3 | Encoded operating mode |
| start_o | output | 1 | One-cycle strobe on sequence entry |
| busy_o | output | 1 | Sequence in progress |
| gpio1_o | output | 1 | GPIO1 pin value |
| gpio2_o | output | 1 | GPIO2 pin value |

## Verification
The bench sweeps every combination of sequence type, CRC result, ending (completion or abort) and GPIO routing. Each case is followed through start, run and exit with exact cycle counts.

It holds the enable high after completion to catch a design that restarts on a level instead of an edge. It toggles the enable during Doze and Hibernate to catch a design that wakes on it or replays the edge after attention. It drives low-power requests during a sequence, which a design that does not restrict entry to Idle would obey. It follows an RX completion with CRC set by a new sequence, to catch a flag that is never cleared. It also asserts reset in the middle of a sequence and counts the cycles after release, which exposes a missing or extra synchronizer stage.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF  = 3'd0,
    MODE_IDLE = 3'd1,
    MODE_RX   = 3'd2,
    MODE_TX   = 3'd3,
    MODE_DOZE = 3'd4,
    MODE_HIB  = 3'd5
  } mode_e;
endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= RST_VAL;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= RST_VAL;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/xcvr_mode_fsm.sv
module xcvr_mode_fsm
  import xcvr_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_s_i,
  input  logic  attn_s_ni,
  input  logic  seq_tx_i,
  input  logic  lp_req_i,
  input  logic  lp_sel_i,
  input  logic  seq_done_i,
  input  logic  crc_ok_i,
  output mode_e mode_o,
  output logic  start_o,
  output logic  busy_o,
  output logic  crc_flag_o
);
  mode_e mode_q, mode_d;
  logic  en_d_q;
  logic  start_q, start_d;
  logic  busy_q, busy_d;
  logic  crc_q, crc_d;
  logic  en_rise;

  // edge tracked in every mode so an edge seen in low power is consumed
  assign en_rise = en_s_i & ~en_d_q;

  always_comb begin
    mode_d  = mode_q;
    start_d = 1'b0;
    busy_d  = busy_q;
    crc_d   = crc_q;
    unique case (mode_q)
      MODE_OFF: mode_d = MODE_IDLE;
      MODE_IDLE: begin
        if (en_rise) begin
          mode_d  = seq_tx_i ? MODE_TX : MODE_RX;
          start_d = 1'b1;
          busy_d  = 1'b1;
          crc_d   = 1'b0;
        end else if (lp_req_i) begin
          mode_d = lp_sel_i ? MODE_HIB : MODE_DOZE;
        end
      end
      MODE_RX, MODE_TX: begin
        if (!en_s_i) begin
          mode_d = MODE_IDLE;
          busy_d = 1'b0;
        end else if (seq_done_i) begin
          mode_d = MODE_IDLE;
          busy_d = 1'b0;
          if (mode_q == MODE_RX) crc_d = crc_ok_i;
        end
      end
      MODE_DOZE, MODE_HIB: begin
        if (!attn_s_ni) mode_d = MODE_IDLE;
      end
      default: mode_d = MODE_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_OFF;
      en_d_q  <= 1'b0;
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      crc_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      en_d_q  <= en_s_i;
      start_q <= start_d;
      busy_q  <= busy_d;
      crc_q   <= crc_d;
    end
  end

  assign mode_o     = mode_q;
  assign start_o    = start_q;
  assign busy_o     = busy_q;
  assign crc_flag_o = crc_q;
endmodule

// File: rtl/xcvr_gpio_mux.sv
module xcvr_gpio_mux #(
  parameter int unsigned NPINS = 2
) (
  input  logic             alt_i,
  input  logic [NPINS-1:0] stat_i,
  input  logic [NPINS-1:0] dflt_i,
  output logic [NPINS-1:0] pin_o
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign pin_o[g] = alt_i ? stat_i[g] : dflt_i[g];
  end
endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
  import xcvr_mode_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trx_en_i,
  input  logic              attn_ni,
  input  logic              seq_tx_i,
  input  logic              lp_req_i,
  input  logic              lp_sel_i,
  input  logic              gpio_alt_i,
  input  logic              seq_done_i,
  input  logic              crc_ok_i,
  input  logic [1:0]        gpio_dflt_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              start_o,
  output logic              busy_o,
  output logic              gpio1_o,
  output logic              gpio2_o
);
  localparam int unsigned NSYNC = 2;

  logic             core_rst_n;
  logic [NSYNC-1:0] pins_s;
  mode_e            mode;
  logic             crc_flag;
  logic             out_of_idle;
  logic [1:0]       gpio_pins;

  // assert asynchronously, release on the clock
  xcvr_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (core_rst_n)
  );

  // bit 1 attention (idle high), bit 0 enable
  xcvr_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(core_rst_n),
    .d_i   ({attn_ni, trx_en_i}),
    .q_o   (pins_s)
  );

  xcvr_mode_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (core_rst_n),
    .en_s_i    (pins_s[0]),
    .attn_s_ni (pins_s[1]),
    .seq_tx_i  (seq_tx_i),
    .lp_req_i  (lp_req_i),
    .lp_sel_i  (lp_sel_i),
    .seq_done_i(seq_done_i),
    .crc_ok_i  (crc_ok_i),
    .mode_o    (mode),
    .start_o   (start_o),
    .busy_o    (busy_o),
    .crc_flag_o(crc_flag)
  );

  assign out_of_idle = (mode == MODE_RX) || (mode == MODE_TX);

  xcvr_gpio_mux #(.NPINS(2)) u_gpio_mux (
    .alt_i (gpio_alt_i),
    .stat_i({crc_flag, out_of_idle}),
    .dflt_i(gpio_dflt_i),
    .pin_o (gpio_pins)
  );

  assign mode_o  = mode;
  assign gpio1_o = gpio_pins[0];
  assign gpio2_o = gpio_pins[1];
endmodule

// File: rtl/xcvr_mode_ctrl_chk.sv
module xcvr_mode_ctrl_chk
  import xcvr_mode_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              gpio_alt_i,
  input logic [MODE_W-1:0] mode_o,
  input logic              start_o,
  input logic              busy_o,
  input logic              gpio1_o
);
  logic in_seq, in_lp;
  assign in_seq = (mode_o == MODE_RX) || (mode_o == MODE_TX);
  assign in_lp  = (mode_o == MODE_DOZE) || (mode_o == MODE_HIB);

  assert_start_in_seq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> in_seq);

  assert_start_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  assert_busy_tracks_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == in_seq);

  assert_seq_entry_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_seq && !($past(mode_o) == MODE_RX || $past(mode_o) == MODE_TX)) |-> start_o);

  assert_lp_from_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_lp && !($past(mode_o) == MODE_DOZE || $past(mode_o) == MODE_HIB))
      |-> ($past(mode_o) == MODE_IDLE));

  assert_no_return_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != MODE_OFF) |=> (mode_o != MODE_OFF));

  assert_ooi_pin_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpio_alt_i && !in_seq) |-> !gpio1_o);
endmodule

bind xcvr_mode_ctrl xcvr_mode_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .gpio_alt_i(gpio_alt_i),
  .mode_o    (mode_o),
  .start_o   (start_o),
  .busy_o    (busy_o),
  .gpio1_o   (gpio1_o)
);

// File: tb/tb_xcvr_mode_ctrl.sv
module tb_xcvr_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni, trx_en, attn_n, seq_tx, lp_req, lp_sel, gpio_alt, seq_done, crc_ok;
  logic [1:0] gpio_dflt;
  logic [2:0] mode;
  logic       start, busy, gpio1, gpio2;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;
  logic       exp_crc;

  always #10 clk = ~clk;

  xcvr_mode_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .trx_en_i(trx_en), .attn_ni(attn_n),
    .seq_tx_i(seq_tx), .lp_req_i(lp_req), .lp_sel_i(lp_sel), .gpio_alt_i(gpio_alt),
    .seq_done_i(seq_done), .crc_ok_i(crc_ok), .gpio_dflt_i(gpio_dflt),
    .mode_o(mode), .start_o(start), .busy_o(busy), .gpio1_o(gpio1), .gpio2_o(gpio2)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b1; trx_en = 1'b0; attn_n = 1'b1; seq_tx = 1'b0; lp_req = 1'b0;
    lp_sel = 1'b0; gpio_alt = 1'b0; seq_done = 1'b0; crc_ok = 1'b0; gpio_dflt = 2'b10;
    exp_crc = 1'b0;
    #2 rst_ni = 1'b0;
    wait_n(3);
    chk("R1 mode in reset", mode, 0);
    chk("R1 start in reset", start, 0);
    chk("R1 busy in reset", busy, 0);
    chk("R9 gpio1 default", gpio1, 0);
    chk("R10 gpio2 default", gpio2, 1);

    rst_ni = 1'b1;
    wait_n(2);
    chk("R2 still off", mode, 0);
    wait_n(1);
    chk("R2 idle", mode, 1);

    // sweep: type, crc result, ending, gpio routing
    for (int idx = 0; idx < 16; idx++) begin
      logic tx, crc, abrt, alt;
      tx = idx[0]; crc = idx[1]; abrt = idx[2]; alt = idx[3];
      seq_tx = tx; crc_ok = crc; gpio_alt = alt;
      trx_en = 1'b1;
      wait_n(2);
      chk("R3 latency", mode, 1);
      wait_n(1);
      exp_crc = 1'b0;
      chk("R3 mode", mode, tx ? 3 : 2);
      chk("R4 start", start, 1);
      chk("R4 busy", busy, 1);
      chk("R9 gpio1 active", gpio1, alt ? 1 : 0);
      chk("R10 gpio2 cleared", gpio2, alt ? 0 : 1);
      lp_req = 1'b1; lp_sel = idx[1];
      wait_n(1);
      lp_req = 1'b0;
      chk("R4 start single", start, 0);
      chk("R4 busy held", busy, 1);
      chk("R7 lp ignored in seq", mode, tx ? 3 : 2);
      if (abrt) begin
        trx_en = 1'b0;
        wait_n(2);
        chk("R5 abort latency", mode, tx ? 3 : 2);
        wait_n(1);
        chk("R5 abort idle", mode, 1);
        chk("R5 busy clear", busy, 0);
        chk("R10 crc after abort", gpio2, alt ? 0 : 1);
      end else begin
        seq_done = 1'b1;
        wait_n(1);
        seq_done = 1'b0;
        exp_crc = tx ? 1'b0 : crc;
        chk("R6 done idle", mode, 1);
        chk("R6 busy clear", busy, 0);
        chk("R10 crc latch", gpio2, alt ? int'(exp_crc) : 1);
        wait_n(4);
        chk("R6 no restart on level", mode, 1);
        chk("R6 no start", start, 0);
        trx_en = 1'b0;
        wait_n(3);
      end
      chk("R9 gpio1 idle", gpio1, 0);
    end

    // low-power entry and wake
    gpio_alt = 1'b0;
    for (int sel = 0; sel < 2; sel++) begin
      lp_sel = sel[0]; lp_req = 1'b1;
      wait_n(1);
      lp_req = 1'b0;
      chk("R7 lp entry", mode, sel ? 5 : 4);
      trx_en = 1'b1;
      wait_n(4);
      chk("R8 enable ignored", mode, sel ? 5 : 4);
      chk("R8 no busy", busy, 0);
      attn_n = 1'b0;
      wait_n(2);
      chk("R8 wake latency", mode, sel ? 5 : 4);
      wait_n(1);
      chk("R8 wake idle", mode, 1);
      attn_n = 1'b1;
      wait_n(4);
      chk("R8 no stale start", mode, 1);
      trx_en = 1'b0;
      wait_n(3);
    end

    attn_n = 1'b0;
    wait_n(4);
    chk("R8 attention in idle", mode, 1);
    attn_n = 1'b1;
    wait_n(3);

    gpio_dflt = 2'b01;
    wait_n(1);
    chk("R9 gpio1 follows default", gpio1, 1);
    chk("R10 gpio2 follows default", gpio2, 0);

    // reset in the middle of a sequence
    seq_tx = 1'b0; trx_en = 1'b1;
    wait_n(3);
    chk("R3 rx before reset", mode, 2);
    #3 rst_ni = 1'b0;
    #1;
    chk("R1 async off", mode, 0);
    chk("R1 async busy", busy, 0);
    @(negedge clk);
    trx_en = 1'b0;
    rst_ni = 1'b1;
    wait_n(2);
    chk("R2 off after reset", mode, 0);
    wait_n(1);
    chk("R2 idle after reset", mode, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule